// File: doc/BRIEF.md
# Serial Byte Port (SPI Target Front End)

This block is the serial entry point of a memory-and-supervisor device. The host drives an active-low chip select, a serial clock and a serial data input. The block frames that bit stream into bytes. It hands each completed byte to the rest of the device as a one-cycle strobe, together with a flag that marks the opcode byte. It also shifts bytes supplied by the device back out on a serial data output, which has its own output-enable. All three pins are brought into the system clock domain through synchronizers, and the block works on edges detected after them.

Until the first high-to-low transition of chip select after power-up, the block refuses all traffic. It tracks that condition with three states. `ST_LOCKED` is the state after reset, and nothing is accepted in it. `ST_IDLE` means armed and deselected. `ST_SHIFT` means selected, with bits moving in both directions. The transitions are:

- `LOCKED -> SHIFT` on the first synchronized chip-select fall.
- `IDLE -> SHIFT` on any later chip-select fall.
- `SHIFT -> IDLE` on a chip-select rise.

No transition leads back into `ST_LOCKED` except reset.

Top module: `serial_byte_port`

## Requirements
- R1: While reset is held and right after it, `armed`, `sdo_oe`, `sdo` and `rx_valid` are all 0.
- R2: If chip select is already low when reset ends, no byte is delivered and `sdo_oe` and `armed` stay 0. This holds until chip select goes high and then low again. Chip select going high alone does not arm the block.
- R3: A synchronized falling edge of chip select sets `armed`, which then stays 1 until reset. The same edge drives `sdo_oe` to 1. A rising edge of chip select returns `sdo_oe` to 0, and `sdo` then reads 0.
- R4: While selected, `sdi_pin` is sampled at each rising serial-clock edge, most significant bit first. After the eighth such edge, `rx_valid` pulses high for exactly one system clock, and `rx_data` then holds the assembled byte.
- R5: `rx_first` is 1 together with the first byte strobe of a frame and 0 with every later strobe of that frame.
- R6: A frame that ends with fewer than eight bits in the current byte produces no strobe for those bits. Bit counting and the first-byte flag restart at the next chip-select fall.
- R7: At a chip-select fall, `tx_data` is captured and its bit 7 appears on `sdo` at once. Bits 6 to 0 follow, one per serial-clock falling edge. At each byte boundary (the eighth rising edge), `tx_data` is captured again, and its bit 7 replaces the old bit 0 at the next falling edge.
- R8: Serial-clock edges while chip select is high are ignored. They produce no strobe and do not move the bit count of the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n_pin | input | 1 | Chip select pin, active low, asynchronous |
| sclk_pin | input | 1 | Serial clock pin, asynchronous |
| sdi_pin | input | 1 | Serial data in pin |
| tx_data | input | DATA_W | Byte to return to the host, captured at frame start and at byte boundaries |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for the serial data out driver (push-pull while 1) |
| armed | output | 1 | A chip-select fall has been seen since reset |
| rx_valid | output | 1 | One-cycle strobe: a received byte is ready |
| rx_data | output | DATA_W | Last received byte |
| rx_first | output | 1 | The strobed byte is the first of its frame (opcode) |

## Verification
The bench first holds chip select low through reset and clocks a full byte. A design that treated a low level as a selection would deliver that byte or enable the output. It then sends frames of several bytes with contrasting data in both directions. This exposes bit-order reversal, an off-by-one in the byte count, and a transmit reload that clobbers bit 0 or lags by one bit. Finally, it aborts a frame after five bits and clocks the serial line while deselected. A block that failed to restart its framing would emit a spurious byte, or would deliver the next frame shifted and without the first-byte flag.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_IDLE   = 2'd1,
        ST_SHIFT  = 2'd2
    } sbp_state_e;
endpackage

// File: rtl/sbp_sync.sv
module sbp_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [STAGES-1:0][WIDTH-1:0] stg_q;
    logic [WIDTH-1:0]             prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q  <= {STAGES{RST_VAL}};
            prev_q <= RST_VAL;
        end else begin
            stg_q  <= {stg_q[STAGES-2:0], d};
            prev_q <= stg_q[STAGES-1];
        end
    end

    assign level = stg_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;
endmodule

// File: rtl/sbp_rx.sv
module sbp_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic              byte_done,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_first
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              first_q;

    assign byte_done = shift_en && !start && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            first_q  <= 1'b1;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_first <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (start) begin
                cnt_q   <= '0;
                first_q <= 1'b1;
            end else if (shift_en) begin
                sh_q <= {sh_q[DATA_W-2:0], bit_in};
                if (cnt_q == LAST) begin
                    cnt_q    <= '0;
                    rx_valid <= 1'b1;
                    rx_data  <= {sh_q[DATA_W-2:0], bit_in};
                    rx_first <= first_q;
                    first_q  <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R4: a received-byte strobe never lasts more than one cycle
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6: framing restarts at a chip-select fall
    p_frame_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == '0) && first_q);
endmodule

// File: rtl/sbp_tx.sv
module sbp_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_now,
    input  logic              load_next,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] tx_data,
    output logic              sdo_bit
);
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] hold_q;
    logic              pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            hold_q <= '0;
            pend_q <= 1'b0;
        end else if (load_now) begin
            sh_q   <= tx_data;
            pend_q <= 1'b0;
        end else begin
            if (shift_en) begin
                if (pend_q) begin
                    sh_q   <= hold_q;
                    pend_q <= 1'b0;
                end else begin
                    sh_q <= {sh_q[DATA_W-2:0], 1'b0};
                end
            end
            if (load_next) begin
                hold_q <= tx_data;
                pend_q <= 1'b1;
            end
        end
    end

    assign sdo_bit = sh_q[DATA_W-1];

    // R7: output bit only moves on a falling serial edge or a frame load
    p_sdo_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !load_now) |=> $stable(sdo_bit));
endmodule

// File: rtl/serial_byte_port.sv
module serial_byte_port
    import sbp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_pin,
    input  logic              sclk_pin,
    input  logic              sdi_pin,
    input  logic [DATA_W-1:0] tx_data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              armed,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_first
);
    localparam int PIN_N = 3;
    localparam int IX_CS = 2;
    localparam int IX_CK = 1;
    localparam int IX_DI = 0;

    logic [PIN_N-1:0] pin_lvl, pin_rise, pin_fall;
    sbp_state_e       state_q, state_d;
    logic             sel, frame_start, sclk_up, sclk_dn, byte_done, sdo_bit;

    // chip select synchronizer resets low so a select held through reset is no edge
    sbp_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cs_n_pin, sclk_pin, sdi_pin}),
        .level(pin_lvl),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (pin_fall[IX_CS]) state_d = ST_SHIFT;
            ST_IDLE:   if (pin_fall[IX_CS]) state_d = ST_SHIFT;
            ST_SHIFT:  if (pin_rise[IX_CS]) state_d = ST_IDLE;
            default:   state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        sel         = 1'b0;
        frame_start = 1'b0;
        armed       = 1'b1;
        unique case (state_q)
            ST_LOCKED: begin
                armed       = 1'b0;
                frame_start = pin_fall[IX_CS];
            end
            ST_IDLE:   frame_start = pin_fall[IX_CS];
            ST_SHIFT:  sel = !pin_rise[IX_CS];
            default:   armed = 1'b0;
        endcase
    end

    assign sclk_up = sel && pin_rise[IX_CK];
    assign sclk_dn = sel && pin_fall[IX_CK];
    assign sdo_oe  = (state_q == ST_SHIFT);
    assign sdo     = sdo_oe & sdo_bit;

    sbp_rx #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (frame_start),
        .shift_en (sclk_up),
        .bit_in   (pin_lvl[IX_DI]),
        .byte_done(byte_done),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_first (rx_first)
    );

    sbp_tx #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_now (frame_start),
        .load_next(byte_done),
        .shift_en (sclk_dn),
        .tx_data  (tx_data),
        .sdo_bit  (sdo_bit)
    );

    // R3: once armed, only reset clears it
    p_armed_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

    // R2: nothing is delivered before the block is armed
    p_locked_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !rx_valid);

    // R8: a byte strobe follows only a cycle spent selected
    p_valid_needs_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(state_q == ST_SHIFT));
endmodule

// File: tb/serial_byte_port_test.sv
module serial_byte_port_test;
    localparam int W    = 8;
    localparam int HALF = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n_pin = 1'b0;
    logic         sclk_pin = 1'b0;
    logic         sdi_pin = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic         sdo, sdo_oe, armed, rx_valid, rx_first;
    logic [W-1:0] rx_data;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;
    logic [W:0] exp_q[$];

    always #2.5 clk = ~clk;

    serial_byte_port uut (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sclk_pin(sclk_pin),
        .sdi_pin(sdi_pin), .tx_data(tx_data), .sdo(sdo), .sdo_oe(sdo_oe),
        .armed(armed), .rx_valid(rx_valid), .rx_data(rx_data), .rx_first(rx_first)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops the scoreboard at every byte strobe (R4, R5)
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errs++;
                $display("FAIL R8 unexpected byte actual=%0h expected=none", {rx_first, rx_data});
            end else begin
                logic [W:0] e;
                e = exp_q.pop_front();
                if ({rx_first, rx_data} !== e) begin
                    errs++;
                    $display("FAIL R4/R5 byte actual=%0h expected=%0h", {rx_first, rx_data}, e);
                end
            end
        end
    end

    task automatic send_bits(input logic [W-1:0] mo, input int n, output logic [W-1:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            sdi_pin = mo[W-1-i];
            wait_clk(HALF);
            got[W-1-i] = sdo;
            sclk_pin = 1'b1;
            wait_clk(HALF);
            sclk_pin = 1'b0;
        end
    endtask

    task automatic frame(input int n, input logic [W-1:0] mo[4], input logic [W-1:0] mi[4]);
        logic [W-1:0] got;
        tx_data  = mi[0];
        cs_n_pin = 1'b0;
        wait_clk(HALF);
        check("R3 oe on select", sdo_oe, 1);
        check("R3 armed after fall", armed, 1);
        for (int k = 0; k < n; k++) begin
            tx_data = (k + 1 < n) ? mi[k+1] : '0;
            exp_q.push_back({(k == 0), mo[k]});
            send_bits(mo[k], W, got);
            check("R7 returned byte", got, mi[k]);
        end
        wait_clk(HALF);
        cs_n_pin = 1'b1;
        wait_clk(HALF);
        check("R3 oe released", sdo_oe, 0);
        check("R3 sdo low when released", sdo, 0);
    endtask

    initial begin
        logic [W-1:0] mo[4];
        logic [W-1:0] mi[4];
        logic [W-1:0] junk;

        // R1: reset state
        wait_clk(3);
        check("R1 armed in reset", armed, 0);
        check("R1 oe in reset", sdo_oe, 0);
        check("R1 sdo in reset", sdo, 0);
        check("R1 valid in reset", rx_valid, 0);
        rst_n = 1'b1;
        wait_clk(4);
        check("R1 armed after reset", armed, 0);

        // R2: select held low from reset is refused
        send_bits(8'h96, W, junk);
        wait_clk(HALF);
        check("R2 not armed", armed, 0);
        check("R2 oe off", sdo_oe, 0);
        cs_n_pin = 1'b1;
        wait_clk(HALF);
        check("R2 high alone does not arm", armed, 0);

        // R4 R5 R7: three-byte frame
        mo = '{8'hA5, 8'h3C, 8'hFF, 8'h00};
        mi = '{8'h5A, 8'h81, 8'h00, 8'h00};
        frame(3, mo, mi);

        // R6: aborted partial byte
        cs_n_pin = 1'b0;
        wait_clk(HALF);
        send_bits(8'hC3, 5, junk);
        wait_clk(HALF);
        cs_n_pin = 1'b1;
        wait_clk(HALF);
        check("R6 oe off after abort", sdo_oe, 0);
        mo = '{8'h01, 8'h80, 8'h00, 8'h00};
        mi = '{8'hC3, 8'h7E, 8'h00, 8'h00};
        frame(2, mo, mi);

        // R8: serial clocks while deselected are ignored
        send_bits(8'hF0, W, junk);
        wait_clk(HALF);
        check("R8 oe stays off", sdo_oe, 0);
        mo = '{8'h69, 8'h00, 8'h00, 8'h00};
        mi = '{8'hB4, 8'h00, 8'h00, 8'h00};
        frame(1, mo, mi);
        check("R3 armed stays set", armed, 1);

        wait_clk(10);
        check("R4 all bytes delivered", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule